// File: doc/BRIEF.md
# Incrementing-pattern lane error checker

This block drives a counting test pattern towards the transmit lanes and checks the pattern after it comes back. Every lane is captured on both clock edges, so each clock cycle gives two words per lane: the rising-edge word and the falling-edge word. A received word is correct only when it is the word just before it on the same lane, plus one. Each received word that breaks this rule counts as one error. This holds inside a cycle (falling word against rising word) and across cycles (rising word against the previous cycle's falling word).

The lanes are grouped into channels. The errors of all lanes of a channel in the same cycle are added, and the total goes into one saturating 16-bit counter per channel. Software starts and stops a counting phase. It can clear the counters without touching the phase. It reads each counter at its own address.

Top module: `lane_pattern_checker`

## Requirements
- R1: After reset every error counter reads 0, `counting` is 0, `tx_rise` is 0 and `tx_fall` is 1.
- R2: `tx_fall` always equals `tx_rise`+1 modulo 2^W. In every cycle after reset both advance by 2, and they wrap from 255 to 0 (W=8).
- R3: A `cmd_start` pulse sets `counting` from the next cycle on. A `cmd_stop` pulse clears it from the next cycle on. When both are asserted in the same cycle, stop wins.
- R4: In a counted valid cycle, the rising word is an error when it differs from the lane's previous falling word plus one. The falling word is an error when it differs from the same cycle's rising word plus one. Each bad word adds exactly 1. 255 followed by 0 is a valid increment.
- R5: The first rising word of a lane after counting begins only sets the reference. It is never flagged, whatever came before.
- R6: Cycles with `rx_valid` low are not checked and leave each lane's reference unchanged.
- R7: While `counting` is 0, received words change no counter.
- R8: Lane l of channel c sits at flat index i=c*N_LANE+l, bits [i*W +: W] of `rx_rise`/`rx_fall`. All errors from a channel's lanes in one cycle are added into that channel's counter only.
- R9: A counter stops at 0xFFFF and never wraps.
- R10: `cmd_clr` zeroes all counters in the next cycle. It leaves `counting` and every lane's reference word unchanged.
- R11: With `rd_en` high, `rd_data` holds the counter of channel n one cycle later when `rd_addr` = 0x100+2n and n < N_CH. Any other address returns 0. An error in a received word reaches its counter two cycles after the word is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| cmd_start | input | 1 | Begin counting phase (pulse) |
| cmd_stop | input | 1 | End counting phase (pulse) |
| cmd_clr | input | 1 | Zero all error counters (pulse) |
| tx_rise | output | W | Pattern word for the rising edge, shared by all lanes |
| tx_fall | output | W | Pattern word for the falling edge, shared by all lanes |
| rx_valid | input | 1 | Received words valid this cycle |
| rx_rise | input | N_CH*N_LANE*W | Rising-edge words of all lanes |
| rx_fall | input | N_CH*N_LANE*W | Falling-edge words of all lanes |
| counting | output | 1 | Counting phase active |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_data | output | CNT_W | Registered read data |

## Verification
A lane whose reference word is wrong shows up as a single unexpected error about two cycles after its next counted word. An out-of-step reference on every lane shows up as counts equal to the lane count per cycle. A counting flag stuck in the wrong state appears on the `counting` port in the cycle after the command. Errors that land in the wrong channel, or an adder that drops a lane, show up as wrong per-channel totals at the next read. A counter that wraps instead of saturating reads a small value instead of 0xFFFF once roughly 11,000 all-bad cycles have passed in the small configuration.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int DEF_CH   = 16;
  localparam int DEF_LANE = 25;
  localparam int DEF_W    = 8;
  localparam int DEF_CNT  = 16;

  // width able to hold the sum of two error bits per lane
  function automatic int sum_width(input int lanes);
    return $clog2(2 * lanes + 1);
  endfunction
endpackage

// File: rtl/lpc_pattern_gen.sv
module lpc_pattern_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] tx_rise,
  output logic [W-1:0] tx_fall
);
  localparam logic [W-1:0] STEP = W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_rise <= '0;
      tx_fall <= W'(1);
    end else begin
      tx_rise <= tx_rise + STEP;
      tx_fall <= tx_fall + STEP;
    end
  end
endmodule

// File: rtl/lpc_lane_check.sv
module lpc_lane_check #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic         counting,
  input  logic [W-1:0] rise_w,
  input  logic [W-1:0] fall_w,
  output logic [1:0]   err
);
  logic [W-1:0] ref_q;
  logic         armed_q;
  logic [W-1:0] ref_inc;
  logic [W-1:0] rise_inc;
  logic         bad_rise;
  logic         bad_fall;

  assign ref_inc  = ref_q + 1'b1;
  assign rise_inc = rise_w + 1'b1;
  assign bad_rise = armed_q && (rise_w != ref_inc);
  assign bad_fall = (fall_w != rise_inc);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= '0;
      armed_q <= 1'b0;
      err     <= '0;
    end else begin
      err <= '0;
      if (!counting) begin
        armed_q <= 1'b0;
      end else if (valid) begin
        err     <= {1'b0, bad_rise} + {1'b0, bad_fall};
        ref_q   <= fall_w;
        armed_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lpc_chan_counter.sv
module lpc_chan_counter
  import lpc_pkg::*;
#(
  parameter int N_LANE = 25,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic [2*N_LANE-1:0]   lane_err,
  output logic [CNT_W-1:0]      cnt
);
  localparam int SUM_W = sum_width(N_LANE);

  logic [SUM_W-1:0] sum;
  logic [CNT_W:0]   total;

  always_comb begin
    sum = '0;
    for (int i = 0; i < N_LANE; i++) begin
      sum = sum + SUM_W'(lane_err[2*i +: 2]);
    end
  end

  assign total = {1'b0, cnt} + {{(CNT_W+1-SUM_W){1'b0}}, sum};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (total[CNT_W]) begin
      cnt <= '1;
    end else begin
      cnt <= total[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/lane_pattern_checker.sv
module lane_pattern_checker
  import lpc_pkg::*;
#(
  parameter int N_CH    = DEF_CH,
  parameter int N_LANE  = DEF_LANE,
  parameter int W       = DEF_W,
  parameter int CNT_W   = DEF_CNT,
  parameter int ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] RD_BASE = ADDR_W'('h100),
  localparam int NL     = N_CH * N_LANE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_clr,
  output logic [W-1:0]      tx_rise,
  output logic [W-1:0]      tx_fall,
  input  logic              rx_valid,
  input  logic [NL*W-1:0]   rx_rise,
  input  logic [NL*W-1:0]   rx_fall,
  output logic              counting,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int IDX_W = ADDR_W - 1;

  logic [2*NL-1:0]       lane_err_flat;
  logic [N_CH*CNT_W-1:0] cnt_flat;
  logic [ADDR_W-1:0]     off;
  logic [CNT_W-1:0]      rd_next;

  // counting phase: stop has priority over start
  always_ff @(posedge clk) begin
    if (rst)            counting <= 1'b0;
    else if (cmd_stop)  counting <= 1'b0;
    else if (cmd_start) counting <= 1'b1;
  end

  lpc_pattern_gen #(.W(W)) u_gen (
    .clk     (clk),
    .rst     (rst),
    .tx_rise (tx_rise),
    .tx_fall (tx_fall)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    for (genvar l = 0; l < N_LANE; l++) begin : g_lane
      localparam int IDX = c * N_LANE + l;
      lpc_lane_check #(.W(W)) u_lane (
        .clk      (clk),
        .rst      (rst),
        .valid    (rx_valid),
        .counting (counting),
        .rise_w   (rx_rise[IDX*W +: W]),
        .fall_w   (rx_fall[IDX*W +: W]),
        .err      (lane_err_flat[2*IDX +: 2])
      );
    end
    lpc_chan_counter #(.N_LANE(N_LANE), .CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .clr      (cmd_clr),
      .lane_err (lane_err_flat[2*c*N_LANE +: 2*N_LANE]),
      .cnt      (cnt_flat[c*CNT_W +: CNT_W])
    );
  end

  // register read decode
  assign off = rd_addr - RD_BASE;

  always_comb begin
    rd_next = '0;
    if (rd_addr >= RD_BASE && !off[0]) begin
      for (int c = 0; c < N_CH; c++) begin
        if (off[ADDR_W-1:1] == IDX_W'(c)) rd_next = cnt_flat[c*CNT_W +: CNT_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker #(
  parameter int N_CH   = 16,
  parameter int N_LANE = 25,
  parameter int W      = 8,
  parameter int CNT_W  = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cmd_start,
  input logic                  cmd_stop,
  input logic                  cmd_clr,
  input logic                  counting,
  input logic [W-1:0]          tx_rise,
  input logic [W-1:0]          tx_fall,
  input logic [2*N_CH*N_LANE-1:0] lane_err_flat,
  input logic [N_CH*CNT_W-1:0] cnt_flat
);
  a_r2_pair: assert property (@(posedge clk) disable iff (rst)
    tx_fall == W'(tx_rise + 1'b1));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tx_rise == W'($past(tx_rise) + W'(2)));

  a_r3_start: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !cmd_stop) |=> counting);

  a_r3_stop: assert property (@(posedge clk) disable iff (rst)
    cmd_stop |=> !counting);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !counting |=> lane_err_flat == '0);

  for (genvar c = 0; c < N_CH; c++) begin : g_c
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
      cmd_clr |=> cnt_flat[c*CNT_W +: CNT_W] == '0);

    a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
      !cmd_clr |=> cnt_flat[c*CNT_W +: CNT_W] >= $past(cnt_flat[c*CNT_W +: CNT_W]));
  end
endmodule

bind lane_pattern_checker lpc_checker #(
  .N_CH(N_CH), .N_LANE(N_LANE), .W(W), .CNT_W(CNT_W)
) u_lpc_checker (
  .clk           (clk),
  .rst           (rst),
  .cmd_start     (cmd_start),
  .cmd_stop      (cmd_stop),
  .cmd_clr       (cmd_clr),
  .counting      (counting),
  .tx_rise       (tx_rise),
  .tx_fall       (tx_fall),
  .lane_err_flat (lane_err_flat),
  .cnt_flat      (cnt_flat)
);

// File: tb/tb_lane_pattern_checker.sv
module tb_lane_pattern_checker;
  localparam int CLK_P  = 10;
  localparam int N_CH   = 4;
  localparam int N_LANE = 3;
  localparam int W      = 8;
  localparam int CNT_W  = 16;
  localparam int NL     = N_CH * N_LANE;
  localparam int MAXC   = (1 << CNT_W) - 1;

  logic clk = 0;
  logic rst = 1;
  logic cmd_start = 0, cmd_stop = 0, cmd_clr = 0;
  logic [W-1:0] tx_rise, tx_fall;
  logic rx_valid = 0;
  logic [NL*W-1:0] rx_rise = '0, rx_fall = '0;
  logic counting;
  logic rd_en = 0;
  logic [15:0] rd_addr = '0;
  logic [CNT_W-1:0] rd_data;

  lane_pattern_checker #(.N_CH(N_CH), .N_LANE(N_LANE), .W(W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_clr(cmd_clr),
    .tx_rise(tx_rise), .tx_fall(tx_fall), .rx_valid(rx_valid), .rx_rise(rx_rise),
    .rx_fall(rx_fall), .counting(counting), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit on = 0;
  logic [W-1:0] rr [NL];
  logic [W-1:0] ff [NL];
  logic [W-1:0] nxt [NL];
  logic [W-1:0] prev [NL];
  bit armed [NL];
  int exp_cnt [N_CH];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic fill_clean();
    for (int l = 0; l < NL; l++) begin
      rr[l] = nxt[l];
      ff[l] = W'(nxt[l] + 1);
      nxt[l] = W'(nxt[l] + 2);
    end
  endtask

  task automatic step(input bit v);
    @(negedge clk);
    rx_valid = v;
    for (int l = 0; l < NL; l++) begin
      rx_rise[l*W +: W] = rr[l];
      rx_fall[l*W +: W] = ff[l];
    end
    if (on && v) begin
      for (int l = 0; l < NL; l++) begin
        int e = 0;
        if (armed[l] && rr[l] != W'(prev[l] + 1)) e++;
        if (ff[l] != W'(rr[l] + 1)) e++;
        exp_cnt[l / N_LANE] = (exp_cnt[l / N_LANE] + e > MAXC) ? MAXC : exp_cnt[l / N_LANE] + e;
        prev[l] = ff[l];
        armed[l] = 1;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0);
  endtask

  task automatic rd(input logic [15:0] a, output int v);
    @(negedge clk);
    rx_valid = 0;
    rd_en = 1;
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
    rd_en = 0;
  endtask

  task automatic check_all(input string req);
    int v;
    idle(3);
    for (int c = 0; c < N_CH; c++) begin
      rd(16'h0100 + 16'(2*c), v);
      check(req, v, exp_cnt[c]);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    rx_valid = 0;
    cmd_start = (which == 0 || which == 3);
    cmd_stop  = (which == 1 || which == 3);
    cmd_clr   = (which == 2);
    @(negedge clk);
    cmd_start = 0; cmd_stop = 0; cmd_clr = 0;
  endtask

  initial begin
    int v;
    logic [W-1:0] last;
    for (int c = 0; c < N_CH; c++) exp_cnt[c] = 0;
    for (int l = 0; l < NL; l++) begin
      nxt[l] = W'(l * 21 + 251);
      armed[l] = 0; prev[l] = '0; rr[l] = '0; ff[l] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 counting", counting, 0);
    check("R1 tx_rise", tx_rise, 0);
    check("R1 tx_fall", tx_fall, 1);
    rst = 0;
    check_all("R1 counters zero / R11 read");

    // R2: pattern generator over more than one wrap
    @(negedge clk);
    last = tx_rise;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      check("R2 step", tx_rise, W'(last + 2));
      check("R2 pair", tx_fall, W'(tx_rise + 1));
      last = tx_rise;
    end

    // R7: words while not counting are ignored
    for (int i = 0; i < 20; i++) begin
      for (int l = 0; l < NL; l++) begin rr[l] = W'(i * 7 + l); ff[l] = W'(i * 3); end
      step(1);
    end
    check_all("R7 idle ignored");

    // R3 start; R4/R5 clean data with wraps, first word arbitrary
    pulse(0); on = 1;
    check("R3 start", counting, 1);
    for (int i = 0; i < 30; i++) begin fill_clean(); step(1); end
    check_all("R4 R5 clean with wrap");

    // R4/R8: single bad words in several lanes in one cycle
    fill_clean();
    rr[0] = W'(rr[0] + 5);
    ff[4] = W'(ff[4] + 9);
    rr[6] = ~rr[6]; rr[7] = ~rr[7]; rr[8] = ~rr[8];
    step(1);
    fill_clean(); step(1);
    check_all("R4 R8 injected");
    check("R8 ch2 six", exp_cnt[2], 6);

    // R6: invalid cycles with garbage do not disturb reference
    for (int i = 0; i < 5; i++) begin
      for (int l = 0; l < NL; l++) begin rr[l] = W'(i * 13); ff[l] = W'(i + 77); end
      step(0);
    end
    for (int i = 0; i < 10; i++) begin fill_clean(); step(1); end
    check_all("R6 gap");

    // R3 stop then R7 corrupted words ignored
    pulse(1); on = 0;
    for (int l = 0; l < NL; l++) armed[l] = 0;
    check("R3 stop", counting, 0);
    for (int i = 0; i < 8; i++) begin
      for (int l = 0; l < NL; l++) begin rr[l] = W'(i * 5); ff[l] = W'(i * 5); end
      step(1);
    end
    check_all("R7 stopped");
    pulse(3);
    check("R3 stop wins", counting, 0);

    // R5: restart with a jump, first word not flagged
    pulse(0); on = 1;
    for (int l = 0; l < NL; l++) nxt[l] = W'(nxt[l] + 100);
    for (int i = 0; i < 6; i++) begin fill_clean(); step(1); end
    check_all("R5 restart");

    // R10: clear keeps phase and references
    pulse(2);
    for (int c = 0; c < N_CH; c++) exp_cnt[c] = 0;
    check("R10 counting kept", counting, 1);
    check_all("R10 cleared");
    for (int i = 0; i < 6; i++) begin fill_clean(); step(1); end
    check_all("R10 reference kept");
    fill_clean(); ff[1] = W'(ff[1] + 1); step(1);
    fill_clean(); step(1);
    check_all("R10 counting continues");

    // R11: unmapped addresses read zero
    rd(16'h0108, v); check("R11 beyond channels", v, 0);
    rd(16'h0101, v); check("R11 odd address", v, 0);
    rd(16'h0000, v); check("R11 below base", v, 0);
    rd(16'h00FE, v); check("R11 just below base", v, 0);

    // R9: saturation on channel 3, all lanes stuck at zero
    for (int i = 0; i < 11000; i++) begin
      fill_clean();
      for (int l = 3 * N_LANE; l < NL; l++) begin rr[l] = '0; ff[l] = '0; end
      step(1);
      if (i == 99) check_all("R9 mid count");
    end
    check_all("R9 saturated");
    check("R9 value", exp_cnt[3], MAXC);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule